// File: doc/BRIEF.md
# Front Panel Word Entry Controller

This block sits between a small board's switches, pushbuttons, LEDs and four 7-segment digits and a 16-bit processor. The operator keys a word one byte at a time on eight switches. Each press of the byte button pushes the byte already held into the upper half of a holding register and puts the switch value into the lower half. Two presses therefore fill the word. Extra presses keep shifting, so a mistake is corrected by simply keying more bytes. The held word only becomes the committed operand when the enter button is pressed.

Three request buttons act on the committed operand. Examine loads it into the address output and pulses an examine request. Deposit loads it into the write-data output and pulses a deposit request together with a write strobe. Start pulses a run request. Each request lasts exactly one clock and restarts the processor's cycle sequencer. A mode button steps the display through four sources: the holding register, the committed operand, the address, and the read-back data from the processor. A one-hot LED group shows which source is active.

All pushbuttons are synchronised and filtered by a counter, so each press yields a single one-clock event. The four digits are scanned one at a time at a rate derived from the clock frequency.

Top module: `panel_word_entry`

## Requirements
- R1: A synchronous reset clears the holding register, the committed operand, `addr_o` and `wdata_o`, selects display mode 0 (`mode_led_o` = 4'b0001), and holds `start_o`, `exam_o`, `dep_o` and `wr_o` low.
- R2: A byte press loads the holding register with {previous low byte, `sw_i`}, so the new byte lands in bits 7:0 and the old low byte moves to bits 15:8.
- R3: Byte presses with no enter keep shifting, so the holding register always holds the last two bytes keyed.
- R4: Only an enter press copies the holding register into the committed operand. Byte presses alone leave the committed operand unchanged.
- R5: A button level held for at least DEB_CYCLES consecutive synchronised clocks counts as one press and yields exactly one action, however long it is held. A pulse shorter than DEB_CYCLES has no effect.
- R6: An examine press copies the committed operand to `addr_o` and raises `exam_o` for one clock in the same cycle. `addr_o` changes at no other time.
- R7: A deposit press copies the committed operand to `wdata_o` and raises `dep_o` and `wr_o` for one clock in the same cycle. `wdata_o` changes at no other time.
- R8: A start press raises `start_o` for one clock and leaves `addr_o` and `wdata_o` unchanged.
- R9: Each mode press advances the display source 0 holding, 1 committed, 2 address, 3 read-back (`rdback_i`), then wraps to 0. `mode_led_o` is one-hot with bit n set for mode n.
- R10: `an_o` is active-low with exactly one bit low. Digit k (`an_o[k]` low) shows bits 4k+3:4k of the selected word. Each digit is held for SCAN_DIV clocks, and the order is 0, 1, 2, 3, then 0 again.
- R11: `seg_o` is active-low with bit 0 = segment a through bit 6 = segment g. Hex digits 0-F use the patterns (gfedcba, 1 = lit) 3F 06 5B 4F 66 6D 7D 07 7F 6F 77 7C 39 5E 79 71.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sw_i | input | 8 | Byte switches |
| btn_byte_i | input | 1 | Byte entry button, raw |
| btn_enter_i | input | 1 | Commit button, raw |
| btn_mode_i | input | 1 | Display mode button, raw |
| btn_start_i | input | 1 | Run request button, raw |
| btn_exam_i | input | 1 | Examine button, raw |
| btn_dep_i | input | 1 | Deposit button, raw |
| rdback_i | input | 16 | Read-back data from the processor |
| start_o | output | 1 | One-clock run request |
| exam_o | output | 1 | One-clock examine request |
| dep_o | output | 1 | One-clock deposit request |
| wr_o | output | 1 | Write strobe accompanying deposit |
| addr_o | output | 16 | Address loaded on examine |
| wdata_o | output | 16 | Write data loaded on deposit |
| mode_led_o | output | 4 | One-hot display mode indicator |
| an_o | output | 4 | Digit enables, active low |
| seg_o | output | 7 | Segments a..g, active low |

## Verification
The assertions check on every cycle the properties that hold at all times. Exactly one digit is enabled and exactly one mode LED is lit. Requests never last two clocks. The address and write-data outputs change only in a cycle that carries the matching request. Only the bench's scenarios can show the values themselves: that shifting keeps the last two bytes, that byte keying does not disturb the committed operand, that a short glitch is ignored while a long hold gives one action, that mode selection wraps, and that each digit shows the right nibble in the right order.

// File: rtl/panel_pkg.sv
package panel_pkg;

   typedef enum logic [1:0] {
      MODE_HOLD   = 2'd0,
      MODE_COMMIT = 2'd1,
      MODE_ADDR   = 2'd2,
      MODE_RDBK   = 2'd3
   } disp_mode_e;

   localparam int N_MODES   = 4;
   localparam int N_BTN     = 6;
   localparam int BTN_BYTE  = 0;
   localparam int BTN_ENTER = 1;
   localparam int BTN_MODE  = 2;
   localparam int BTN_START = 3;
   localparam int BTN_EXAM  = 4;
   localparam int BTN_DEP   = 5;

   // Segment pattern, active high, bit 0 = a ... bit 6 = g
   function automatic logic [6:0] hex_to_seg(input logic [3:0] nib);
      logic [6:0] s;
      case (nib)
         4'h0: s = 7'h3F;  4'h1: s = 7'h06;  4'h2: s = 7'h5B;  4'h3: s = 7'h4F;
         4'h4: s = 7'h66;  4'h5: s = 7'h6D;  4'h6: s = 7'h7D;  4'h7: s = 7'h07;
         4'h8: s = 7'h7F;  4'h9: s = 7'h6F;  4'hA: s = 7'h77;  4'hB: s = 7'h7C;
         4'hC: s = 7'h39;  4'hD: s = 7'h5E;  4'hE: s = 7'h79;  default: s = 7'h71;
      endcase
      return s;
   endfunction

endpackage

// File: rtl/panel_pb_filter.sv
module panel_pb_filter #(
   parameter int DEB_CYCLES = 4
) (
   input  logic clk,
   input  logic rst,
   input  logic raw_i,
   output logic press_o
);
   localparam int CW = $clog2(DEB_CYCLES + 1);

   logic [1:0]    sync_q;
   logic          level_q;
   logic [CW-1:0] cnt_q;
   logic          differ;
   logic          settle;

   assign differ = (sync_q[1] != level_q);
   assign settle = differ && (cnt_q == CW'(DEB_CYCLES - 1));

   always_ff @(posedge clk) begin
      if (rst) begin
         sync_q  <= '0;
         level_q <= 1'b0;
         cnt_q   <= '0;
         press_o <= 1'b0;
      end else begin
         sync_q  <= {sync_q[0], raw_i};
         press_o <= settle && sync_q[1];
         if (!differ) begin
            cnt_q <= '0;
         end else if (settle) begin
            cnt_q   <= '0;
            level_q <= sync_q[1];
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/panel_word_shift.sv
module panel_word_shift #(
   parameter int SW_W = 8,
   localparam int WORD_W = 2 * SW_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              shift_i,
   input  logic              commit_i,
   input  logic [SW_W-1:0]   sw_i,
   output logic [WORD_W-1:0] hold_o,
   output logic [WORD_W-1:0] commit_o
);
   always_ff @(posedge clk) begin
      if (rst) begin
         hold_o   <= '0;
         commit_o <= '0;
      end else begin
         if (shift_i)  hold_o   <= {hold_o[SW_W-1:0], sw_i};
         if (commit_i) commit_o <= hold_o;
      end
   end
endmodule

// File: rtl/panel_hex_scan.sv
module panel_hex_scan
   import panel_pkg::*;
#(
   parameter int WORD_W         = 16,
   parameter int SCAN_DIV       = 8,
   parameter bit SEG_ACTIVE_LOW = 1'b1,
   parameter bit AN_ACTIVE_LOW  = 1'b1,
   localparam int NDIG = WORD_W / 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [WORD_W-1:0] value_i,
   output logic [NDIG-1:0]   an_o,
   output logic [6:0]        seg_o
);
   localparam int IW = $clog2(NDIG);
   localparam int PW = $clog2(SCAN_DIV);

   logic [PW-1:0]   pre_q;
   logic [IW-1:0]   dig_q;
   logic [3:0]      nibble;
   logic [6:0]      seg_hi;
   logic [NDIG-1:0] an_hi;

   always_ff @(posedge clk) begin
      if (rst) begin
         pre_q <= '0;
         dig_q <= '0;
      end else if (pre_q == PW'(SCAN_DIV - 1)) begin
         pre_q <= '0;
         dig_q <= (dig_q == IW'(NDIG - 1)) ? '0 : dig_q + 1'b1;
      end else begin
         pre_q <= pre_q + 1'b1;
      end
   end

   assign nibble = value_i[{dig_q, 2'b00} +: 4];
   assign seg_hi = hex_to_seg(nibble);
   assign an_hi  = NDIG'(1) << dig_q;

   generate
      if (SEG_ACTIVE_LOW) begin : g_seg_low
         assign seg_o = ~seg_hi;
      end else begin : g_seg_high
         assign seg_o = seg_hi;
      end
      if (AN_ACTIVE_LOW) begin : g_an_low
         assign an_o = ~an_hi;
      end else begin : g_an_high
         assign an_o = an_hi;
      end
   endgenerate
endmodule

// File: rtl/panel_word_entry.sv
module panel_word_entry
   import panel_pkg::*;
#(
   parameter int CLK_HZ         = 50_000_000,
   parameter int REFRESH_HZ     = 1000,
   parameter int DEBOUNCE_US    = 5000,
   parameter int SW_W           = 8,
   parameter bit SEG_ACTIVE_LOW = 1'b1,
   localparam int WORD_W = 2 * SW_W,
   localparam int NDIG   = WORD_W / 4
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [SW_W-1:0]    sw_i,
   input  logic               btn_byte_i,
   input  logic               btn_enter_i,
   input  logic               btn_mode_i,
   input  logic               btn_start_i,
   input  logic               btn_exam_i,
   input  logic               btn_dep_i,
   input  logic [WORD_W-1:0]  rdback_i,
   output logic               start_o,
   output logic               exam_o,
   output logic               dep_o,
   output logic               wr_o,
   output logic [WORD_W-1:0]  addr_o,
   output logic [WORD_W-1:0]  wdata_o,
   output logic [N_MODES-1:0] mode_led_o,
   output logic [NDIG-1:0]    an_o,
   output logic [6:0]         seg_o
);
   localparam int DEB_CYCLES = int'((longint'(CLK_HZ) * longint'(DEBOUNCE_US)) / 64'd1000000);
   localparam int SCAN_DIV   = CLK_HZ / (REFRESH_HZ * NDIG);

   generate
      if (SW_W < 4 || (SW_W % 2) != 0) begin : g_bad_sw
         $error("SW_W must be even and at least 4");
      end
      if (DEB_CYCLES < 1) begin : g_bad_deb
         $error("debounce window shorter than one clock");
      end
      if (SCAN_DIV < 2) begin : g_bad_scan
         $error("refresh divider below 2");
      end
   endgenerate

   logic [N_BTN-1:0]  btn_raw;
   logic [N_BTN-1:0]  press;
   logic [WORD_W-1:0] hold_w;
   logic [WORD_W-1:0] commit_w;
   logic [WORD_W-1:0] shown;
   disp_mode_e        mode_q;

   assign btn_raw[BTN_BYTE]  = btn_byte_i;
   assign btn_raw[BTN_ENTER] = btn_enter_i;
   assign btn_raw[BTN_MODE]  = btn_mode_i;
   assign btn_raw[BTN_START] = btn_start_i;
   assign btn_raw[BTN_EXAM]  = btn_exam_i;
   assign btn_raw[BTN_DEP]   = btn_dep_i;

   generate
      for (genvar b = 0; b < N_BTN; b++) begin : g_btn
         panel_pb_filter #(.DEB_CYCLES(DEB_CYCLES)) u_filt (
            .clk     (clk),
            .rst     (rst),
            .raw_i   (btn_raw[b]),
            .press_o (press[b])
         );
      end
   endgenerate

   panel_word_shift #(.SW_W(SW_W)) u_shift (
      .clk      (clk),
      .rst      (rst),
      .shift_i  (press[BTN_BYTE]),
      .commit_i (press[BTN_ENTER]),
      .sw_i     (sw_i),
      .hold_o   (hold_w),
      .commit_o (commit_w)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         start_o <= 1'b0;
         exam_o  <= 1'b0;
         dep_o   <= 1'b0;
         wr_o    <= 1'b0;
         addr_o  <= '0;
         wdata_o <= '0;
         mode_q  <= MODE_HOLD;
      end else begin
         start_o <= press[BTN_START];
         exam_o  <= press[BTN_EXAM];
         dep_o   <= press[BTN_DEP];
         wr_o    <= press[BTN_DEP];
         if (press[BTN_EXAM]) addr_o  <= commit_w;
         if (press[BTN_DEP])  wdata_o <= commit_w;
         if (press[BTN_MODE]) begin
            mode_q <= (mode_q == MODE_RDBK) ? MODE_HOLD : disp_mode_e'(mode_q + 2'd1);
         end
      end
   end

   assign mode_led_o = N_MODES'(1) << mode_q;

   always_comb begin
      case (mode_q)
         MODE_HOLD:   shown = hold_w;
         MODE_COMMIT: shown = commit_w;
         MODE_ADDR:   shown = addr_o;
         default:     shown = rdback_i;
      endcase
   end

   panel_hex_scan #(
      .WORD_W         (WORD_W),
      .SCAN_DIV       (SCAN_DIV),
      .SEG_ACTIVE_LOW (SEG_ACTIVE_LOW),
      .AN_ACTIVE_LOW  (1'b1)
   ) u_scan (
      .clk     (clk),
      .rst     (rst),
      .value_i (shown),
      .an_o    (an_o),
      .seg_o   (seg_o)
   );
endmodule

// File: rtl/panel_word_entry_chk.sv
module panel_word_entry_chk #(
   parameter int WORD_W = 16,
   localparam int NDIG = WORD_W / 4
) (
   input logic              clk,
   input logic              rst,
   input logic              start_o,
   input logic              exam_o,
   input logic              dep_o,
   input logic [WORD_W-1:0] addr_o,
   input logic [WORD_W-1:0] wdata_o,
   input logic [3:0]        mode_led_o,
   input logic [NDIG-1:0]   an_o
);
   assert_one_digit_R10: assert property (@(posedge clk) disable iff (rst)
      $countones(~an_o) == 1);

   assert_mode_onehot_R9: assert property (@(posedge clk) disable iff (rst)
      $countones(mode_led_o) == 1);

   assert_start_single_R8: assert property (@(posedge clk) disable iff (rst)
      start_o |=> !start_o);

   assert_exam_single_R5: assert property (@(posedge clk) disable iff (rst)
      exam_o |=> !exam_o);

   assert_dep_single_R7: assert property (@(posedge clk) disable iff (rst)
      dep_o |=> !dep_o);

   assert_addr_on_exam_R6: assert property (@(posedge clk) disable iff (rst)
      !$stable(addr_o) |-> exam_o);

   assert_wdata_on_dep_R7: assert property (@(posedge clk) disable iff (rst)
      !$stable(wdata_o) |-> dep_o);
endmodule

bind panel_word_entry panel_word_entry_chk #(.WORD_W(WORD_W)) u_chk (.*);

// File: tb/panel_word_entry_bench.sv
module panel_word_entry_bench;
   localparam int DEB  = 4;   // 32000 Hz * 125 us
   localparam int SCAN = 8;   // 32000 / (1000 * 4)

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [7:0]  sw  = '0;
   logic        b_byte = 0, b_enter = 0, b_mode = 0, b_start = 0, b_exam = 0, b_dep = 0;
   logic [15:0] rdback = '0;
   logic        start_o, exam_o, dep_o, wr_o;
   logic [15:0] addr_o, wdata_o;
   logic [3:0]  mode_led_o, an_o;
   logic [6:0]  seg_o;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 0;

   typedef struct { int kind; logic [15:0] val; } req_t;  // 1 start, 2 exam, 3 dep
   req_t exp_q[$];

   always #2 clk = ~clk;

   panel_word_entry #(.CLK_HZ(32000), .REFRESH_HZ(1000), .DEBOUNCE_US(125)) u_panel_word_entry (
      .clk(clk), .rst(rst), .sw_i(sw),
      .btn_byte_i(b_byte), .btn_enter_i(b_enter), .btn_mode_i(b_mode),
      .btn_start_i(b_start), .btn_exam_i(b_exam), .btn_dep_i(b_dep),
      .rdback_i(rdback), .start_o(start_o), .exam_o(exam_o), .dep_o(dep_o), .wr_o(wr_o),
      .addr_o(addr_o), .wdata_o(wdata_o), .mode_led_o(mode_led_o), .an_o(an_o), .seg_o(seg_o)
   );

   function automatic logic [6:0] seg_of(input logic [3:0] n);
      logic [6:0] p;
      case (n)
         4'h0: p = 7'h3F;  4'h1: p = 7'h06;  4'h2: p = 7'h5B;  4'h3: p = 7'h4F;
         4'h4: p = 7'h66;  4'h5: p = 7'h6D;  4'h6: p = 7'h7D;  4'h7: p = 7'h07;
         4'h8: p = 7'h7F;  4'h9: p = 7'h6F;  4'hA: p = 7'h77;  4'hB: p = 7'h7C;
         4'hC: p = 7'h39;  4'hD: p = 7'h5E;  4'hE: p = 7'h79;  default: p = 7'h71;
      endcase
      return ~p;
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Scoreboard monitor: pops one expected request per observed request cycle
   always @(negedge clk) begin
      if (!rst && (start_o || exam_o || dep_o)) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R5 unexpected request", {29'd0, start_o, exam_o, dep_o}, 32'd0);
         end else begin
            req_t e;
            int   k;
            e = exp_q.pop_front();
            k = start_o ? 1 : exam_o ? 2 : 3;
            chk(k == e.kind && $countones({start_o, exam_o, dep_o}) == 1, "R5 request kind", k, e.kind);
            if (e.kind == 2) chk(addr_o == e.val, "R6 addr on exam", addr_o, e.val);
            if (e.kind == 3) begin
               chk(wdata_o == e.val, "R7 wdata on deposit", wdata_o, e.val);
               chk(wr_o == 1'b1, "R7 write strobe", wr_o, 1);
            end
         end
      end
   end

   task automatic press(ref logic b);
      b = 1'b1;
      repeat (DEB + 8) @(posedge clk);
      b = 1'b0;
      repeat (DEB + 8) @(posedge clk);
   endtask

   task automatic glitch(ref logic b);
      b = 1'b1;
      repeat (DEB - 1) @(posedge clk);
      b = 1'b0;
      repeat (DEB + 8) @(posedge clk);
   endtask

   task automatic key_byte(input logic [7:0] v);
      sw = v;
      press(b_byte);
   endtask

   task automatic check_disp(input logic [15:0] v, input string req);
      for (int d = 0; d < 4; d++) begin
         @(negedge clk);
         while (an_o != ~(4'b1 << d)) @(negedge clk);
         chk(seg_o == seg_of(v[4*d +: 4]), req, {25'd0, seg_o}, {25'd0, seg_of(v[4*d +: 4])});
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         chk(1'b0, "watchdog", 0, 1);
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: reset state
      chk(mode_led_o == 4'b0001, "R1 mode led", mode_led_o, 4'b0001);
      chk({start_o, exam_o, dep_o, wr_o} == 4'b0, "R1 requests low", {start_o, exam_o, dep_o, wr_o}, 0);
      chk(addr_o == 16'h0 && wdata_o == 16'h0, "R1 addr/wdata clear", {addr_o, wdata_o}, 0);
      rst = 1'b0;
      check_disp(16'h0000, "R1 hold clear");

      // R2: first two bytes
      key_byte(8'hA5);
      check_disp(16'h00A5, "R2 first byte low half");
      key_byte(8'h3C);
      check_disp(16'hA53C, "R2 second byte shifts up");

      // R3: a third byte drops the oldest
      key_byte(8'h12);
      key_byte(8'h34);
      key_byte(8'h56);
      check_disp(16'h3456, "R3 last two bytes");

      // R4: committed stays 0 until enter
      press(b_mode);
      chk(mode_led_o == 4'b0010, "R9 mode 1 led", mode_led_o, 4'b0010);
      check_disp(16'h0000, "R4 no commit before enter");
      press(b_enter);
      check_disp(16'h3456, "R4 enter commits");
      key_byte(8'h77);
      check_disp(16'h3456, "R4 byte keeps committed");

      // R5: short glitches ignored
      glitch(b_mode);
      chk(mode_led_o == 4'b0010, "R5 glitch ignored", mode_led_o, 4'b0010);
      glitch(b_start);
      glitch(b_exam);
      chk(addr_o == 16'h0, "R5 glitch exam ignored", addr_o, 0);

      // R6: examine, long hold gives a single request
      exp_q.push_back('{2, 16'h3456});
      b_exam = 1'b1;
      repeat (6 * DEB) @(posedge clk);
      b_exam = 1'b0;
      repeat (DEB + 8) @(posedge clk);
      chk(addr_o == 16'h3456, "R6 addr held", addr_o, 16'h3456);
      press(b_mode);
      chk(mode_led_o == 4'b0100, "R9 mode 2 led", mode_led_o, 4'b0100);
      check_disp(16'h3456, "R9 address shown");

      // R7: deposit of new commit
      press(b_enter);
      exp_q.push_back('{3, 16'h5677});
      press(b_dep);
      chk(wdata_o == 16'h5677, "R7 wdata held", wdata_o, 16'h5677);
      chk(addr_o == 16'h3456, "R7 addr untouched", addr_o, 16'h3456);

      // R8: start leaves operands alone
      exp_q.push_back('{1, 16'h0});
      press(b_start);
      chk(addr_o == 16'h3456 && wdata_o == 16'h5677, "R8 operands unchanged",
          {addr_o, wdata_o}, {16'h3456, 16'h5677});

      // R9/R11: read-back mode covering every hex digit
      press(b_mode);
      chk(mode_led_o == 4'b1000, "R9 mode 3 led", mode_led_o, 4'b1000);
      rdback = 16'h0123; check_disp(16'h0123, "R11 digits 0-3");
      rdback = 16'h4567; check_disp(16'h4567, "R11 digits 4-7");
      rdback = 16'h89AB; check_disp(16'h89AB, "R11 digits 8-B");
      rdback = 16'hCDEF; check_disp(16'hCDEF, "R11 digits C-F");
      press(b_mode);
      chk(mode_led_o == 4'b0001, "R9 wrap to mode 0", mode_led_o, 4'b0001);
      check_disp(16'h5677, "R9 hold shown after wrap");

      // R10: scan dwell and order
      begin
         logic [3:0] a0, nxt;
         @(negedge clk);
         a0 = an_o;
         while (an_o == a0) @(negedge clk);
         a0 = an_o;
         repeat (SCAN - 1) @(negedge clk);
         chk(an_o == a0, "R10 dwell", an_o, a0);
         @(negedge clk);
         nxt = ~{~a0[2:0], ~a0[3]};
         chk(an_o == nxt, "R10 order", an_o, nxt);
      end

      // R1: reset after activity
      rst = 1'b1;
      repeat (2) @(posedge clk);
      @(negedge clk);
      chk(addr_o == 16'h0 && wdata_o == 16'h0, "R1 operands cleared", {addr_o, wdata_o}, 0);
      chk(mode_led_o == 4'b0001, "R1 mode reset", mode_led_o, 4'b0001);
      rst = 1'b0;
      check_disp(16'h0000, "R1 hold cleared");

      chk(exp_q.size() == 0, "R5 every request seen once", exp_q.size(), 0);
      done = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule